// File: doc/BRIEF.md
# Compensated Three-Level Force-Feedback Sequencer

This block sits on the digital side of a force-balanced capacitive accelerometer loop. Once per sample it takes the single bit from a two-level delta-sigma quantizer and treats it as +1 (bit high) or -1 (bit low). It then forms a first difference against the previous sample, which gives a compensating zero that keeps the loop stable. The difference can only be +2, 0 or -2. It is presented as a small signed code and also as three exclusive level flags.

A free-running counter divides each sample period into four fast-clock phases. The block drives the feedback switch enables only in the last two phases. A +2 code pushes the proof mass in the positive direction for both phases, and a -2 code pushes it in the negative direction for both. A zero code applies one phase of each direction, so the net force averages out. The order of the two directions swaps on every zero-code sample, which makes mismatch between the two force levels first-order shaped.

Top module: `force_fb_sequencer`

## Requirements
- R1: During and right after reset the phase output is 0, the code is 0 with only the mid flag set, and sampleValid is low. The stored previous sample is +1, and the mid-order state is positive-first.
- R2: The phase output counts 0,1,2,3,0,... one step per clock. The values 0 to 3 stand for phases 1 to 4.
- R3: The code is the current sample minus the previous sample, with bit 1 = +1 and bit 0 = -1. It is a 3-bit two's-complement value: +2 = 3'b010, 0 = 3'b000, -2 = 3'b110.
- R4: Exactly one flag is high: flagHigh for +2, flagMid for 0, flagLow for -2.
- R5: quantBit is sampled only at the clock edge that ends phase 4 (phase output 3). Code and flags change only at that edge and hold through the next four phases. sampleValid is high exactly during phase 1 (phase output 0) after a sample has been taken.
- R6: All six feedback outputs are low during phases 1 and 2.
- R7: For a +2 code, swHigh and drivePos are high in phases 3 and 4. For a -2 code, swLow and driveNeg are high in phases 3 and 4.
- R8: For a 0 code, swMidEarly is high in phase 3 and swMidLate in phase 4. drivePos and driveNeg each take exactly one of these two phases.
- R9: Each zero-code sample taken toggles the direction order. The k-th such sample after reset is negative-first when k is odd and positive-first when k is even. Before the first sample the order is positive-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rstN | input | 1 | Active-low synchronous reset |
| quantBit | input | 1 | Quantizer decision, 1 = +1, 0 = -1 |
| phase | output | 2 | Current phase, 0..3 = phase 1..4 |
| code | output | 3 | Compensator output, signed |
| flagHigh | output | 1 | Code is +2 |
| flagMid | output | 1 | Code is 0 |
| flagLow | output | 1 | Code is -2 |
| sampleValid | output | 1 | New sample presented (phase 1) |
| swHigh | output | 1 | Positive-level switch enable |
| swLow | output | 1 | Negative-level switch enable |
| swMidEarly | output | 1 | Zero-level enable, phase 3 |
| swMidLate | output | 1 | Zero-level enable, phase 4 |
| drivePos | output | 1 | Force applied in positive direction now |
| driveNeg | output | 1 | Force applied in negative direction now |

## Verification
The assertions check on every cycle that the phase steps in order and that the code only takes the three legal values. They also check that exactly one flag is set, that the code holds between sample edges, that nothing drives force in phases 1 and 2, and that a zero code reverses direction between phases 3 and 4. Two things only the bench's scenarios can show. The first is whether the difference is taken against the right earlier sample. The second is whether the zero-code order alternates correctly across runs of zero codes separated by nonzero ones. The bench tracks both against its own model over random and directed bit sequences.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
  // Strobes passed from the phase control to the datapath.
  typedef struct packed {
    logic loadNow;   // last phase: sample edge closes this cycle
    logic inFirst;   // phase 1
    logic inEarly;   // first force phase (phase 3)
    logic inLate;    // second force phase (phase 4)
  } phaseStrobe_t;
endpackage

// File: rtl/ffb_phase_ctrl.sv
module ffb_phase_ctrl
  import ffb_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  localparam int PW = $clog2(NUM_PHASES)
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [PW-1:0] phaseIdx,
  output phaseStrobe_t  strb
);
  localparam logic [PW-1:0] LAST  = PW'(NUM_PHASES - 1);
  localparam logic [PW-1:0] EARLY = PW'(NUM_PHASES - 2);

  always_ff @(posedge clk) begin
    if (!rstN) phaseIdx <= '0;
    else if (phaseIdx == LAST) phaseIdx <= '0;
    else phaseIdx <= phaseIdx + 1'b1;
  end

  always_comb begin
    strb.loadNow = (phaseIdx == LAST);
    strb.inFirst = (phaseIdx == '0);
    strb.inEarly = (phaseIdx == EARLY);
    strb.inLate  = (phaseIdx == LAST);
  end

  // R2: phase advances by one and wraps after the last phase
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(phaseIdx) != LAST) |-> phaseIdx == $past(phaseIdx) + 1'b1);
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(phaseIdx) == LAST) |-> phaseIdx == '0);
endmodule

// File: rtl/ffb_datapath.sv
module ffb_datapath
  import ffb_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  phaseStrobe_t             strb,
  input  logic                     quantBit,
  output logic signed [CODE_W-1:0] code,
  output logic                     flagHigh,
  output logic                     flagMid,
  output logic                     flagLow,
  output logic                     sampleValid,
  output logic                     swHigh,
  output logic                     swLow,
  output logic                     swMidEarly,
  output logic                     swMidLate,
  output logic                     drivePos,
  output logic                     driveNeg
);
  localparam logic signed [CODE_W-1:0] PLUS_ONE  = CODE_W'(1);
  localparam logic signed [CODE_W-1:0] MINUS_ONE = CODE_W'(-1);
  localparam logic signed [CODE_W-1:0] PLUS_TWO  = CODE_W'(2);
  localparam logic signed [CODE_W-1:0] MINUS_TWO = CODE_W'(-2);

  logic                     prevBit;
  logic                     flipQ;
  logic signed [CODE_W-1:0] curVal, prevVal, diffVal;

  always_comb begin
    curVal  = quantBit ? PLUS_ONE : MINUS_ONE;
    prevVal = prevBit  ? PLUS_ONE : MINUS_ONE;
    diffVal = curVal - prevVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit     <= 1'b1;
      code        <= '0;
      flipQ       <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strb.loadNow;
      if (strb.loadNow) begin
        prevBit <= quantBit;
        code    <= diffVal;
        if (diffVal == '0) flipQ <= ~flipQ;
      end
    end
  end

  always_comb begin
    flagHigh   = (code == PLUS_TWO);
    flagLow    = (code == MINUS_TWO);
    flagMid    = (code == '0);
    swHigh     = flagHigh & (strb.inEarly | strb.inLate);
    swLow      = flagLow  & (strb.inEarly | strb.inLate);
    swMidEarly = flagMid  & strb.inEarly;
    swMidLate  = flagMid  & strb.inLate;
    drivePos   = swHigh | (swMidEarly & ~flipQ) | (swMidLate & flipQ);
    driveNeg   = swLow  | (swMidEarly & flipQ)  | (swMidLate & ~flipQ);
  end

  // R3: only the three legal levels appear
  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    code == PLUS_TWO || code == MINUS_TWO || code == '0);
  // R4: exactly one level flag
  a_r4_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({flagHigh, flagMid, flagLow}));
  // R5: code holds except across the sample edge
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inFirst) |-> $stable(code));
  // R8: zero code reverses direction from phase 3 to phase 4
  a_r8_mid_reverse: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inLate && flagMid && $past(rstN)) |-> (drivePos == $past(driveNeg) && driveNeg == $past(drivePos)));
endmodule

// File: rtl/force_fb_sequencer.sv
module force_fb_sequencer
  import ffb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       quantBit,
  output logic [1:0] phase,
  output logic [2:0] code,
  output logic       flagHigh,
  output logic       flagMid,
  output logic       flagLow,
  output logic       sampleValid,
  output logic       swHigh,
  output logic       swLow,
  output logic       swMidEarly,
  output logic       swMidLate,
  output logic       drivePos,
  output logic       driveNeg
);
  phaseStrobe_t strb;
  logic signed [2:0] codeS;

  ffb_phase_ctrl #(.NUM_PHASES(4)) ctrl_i (
    .clk(clk), .rstN(rstN), .phaseIdx(phase), .strb(strb)
  );

  ffb_datapath #(.CODE_W(3)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .quantBit(quantBit),
    .code(codeS), .flagHigh(flagHigh), .flagMid(flagMid), .flagLow(flagLow),
    .sampleValid(sampleValid), .swHigh(swHigh), .swLow(swLow),
    .swMidEarly(swMidEarly), .swMidLate(swMidLate),
    .drivePos(drivePos), .driveNeg(driveNeg)
  );

  assign code = codeS;

  // R6: no feedback outside phases 3 and 4
  a_r6_quiet_early: assert property (@(posedge clk) disable iff (!rstN)
    (phase < 2'd2) |-> !(swHigh | swLow | swMidEarly | swMidLate | drivePos | driveNeg));
  // R5: valid strobe only in phase 1
  a_r5_valid_phase: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> phase == 2'd0);
endmodule

// File: tb/force_fb_sequencer_tb.sv
module force_fb_sequencer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic quantBit = 1'b0;
  logic [1:0] phase;
  logic [2:0] code;
  logic flagHigh, flagMid, flagLow, sampleValid;
  logic swHigh, swLow, swMidEarly, swMidLate, drivePos, driveNeg;

  int nChecks = 0;
  int nFails = 0;
  int mPrev = 1;
  bit mFlip = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  force_fb_sequencer dut_i (
    .clk(clk), .rstN(rstN), .quantBit(quantBit), .phase(phase), .code(code),
    .flagHigh(flagHigh), .flagMid(flagMid), .flagLow(flagLow),
    .sampleValid(sampleValid), .swHigh(swHigh), .swLow(swLow),
    .swMidEarly(swMidEarly), .swMidLate(swMidLate),
    .drivePos(drivePos), .driveNeg(driveNeg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int encOut(input int p, input int c, input bit flip);
    // packs the expected six feedback outputs: swHigh,swLow,mE,mL,pos,neg
    bit hi, lo, mi, fe, la, mE, mL, pos, neg;
    hi = (c == 2); lo = (c == -2); mi = (c == 0);
    fe = (p == 2); la = (p == 3);
    mE = mi && fe; mL = mi && la;
    pos = (hi && (fe || la)) || (mE && !flip) || (mL && flip);
    neg = (lo && (fe || la)) || (mE && flip) || (mL && !flip);
    return {hi && (fe || la), lo && (fe || la), mE, mL, pos, neg};
  endfunction

  // Presents one bit at phase 4, then checks all four phases of the result.
  task automatic runSample(input bit b);
    int cur, expCode, got;
    while (phase != 2'd3) @(negedge clk);
    quantBit = b;
    cur = b ? 1 : -1;
    expCode = cur - mPrev;
    mPrev = cur;
    if (expCode == 0) mFlip = ~mFlip;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      quantBit = ~b; // R5: changing the bit mid-cycle must have no effect
      chk(phase == 2'(p), "R2 phase", phase, p);
      chk($signed(code) == expCode, "R3 code", $signed(code), expCode);
      chk({flagHigh, flagMid, flagLow} == {expCode == 2, expCode == 0, expCode == -2},
          "R4 flags", {flagHigh, flagMid, flagLow}, {expCode == 2, expCode == 0, expCode == -2});
      chk(sampleValid == (p == 0), "R5 valid", sampleValid, p == 0);
      got = {swHigh, swLow, swMidEarly, swMidLate, drivePos, driveNeg};
      if (p < 2)
        chk(got == 0, "R6 quiet", got, 0);
      else if (expCode == 0)
        chk(got == encOut(p, expCode, mFlip), "R8/R9 mid order", got, encOut(p, expCode, mFlip));
      else
        chk(got == encOut(p, expCode, mFlip), "R7 full force", got, encOut(p, expCode, mFlip));
    end
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(phase == 0, "R1 phase", phase, 0);
    chk(code == 3'b000 && flagMid && !flagHigh && !flagLow, "R1 code", code, 0);
    chk(!sampleValid, "R1 valid", sampleValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(phase == 2'd1, "R2 first step", phase, 1);
    @(negedge clk);
    // R1/R9: before any sample a zero code is positive-first
    chk({drivePos, driveNeg} == 2'b10, "R9 reset order", {drivePos, driveNeg}, 2);
    // directed: R1 previous is +1, so bit 0 gives -2 then repeated mids
    runSample(1'b0);
    chk(code == 3'b110, "R3 minus two encoding", code, 6);
    runSample(1'b1);
    chk(code == 3'b010, "R3 plus two encoding", code, 2);
    runSample(1'b1);  // mid k=1: negative first
    runSample(1'b1);  // mid k=2: positive first
    runSample(1'b1);
    runSample(1'b0);
    runSample(1'b0);  // mid after nonzero
    runSample(1'b1);
    runSample(1'b0);
    for (int i = 0; i < 400; i++) runSample(1'($urandom() & 1));
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule